// File: doc/BRIEF.md
# Zero-Phase-Start Lock Sequencer

This block controls a recovered-clock oscillator when a read begins, so that the oscillator comes up phase-aligned with the incoming encoded data. It does not let a feedback loop slew slowly toward phase. Instead, it stops the oscillator briefly and restarts it exactly on a chosen data edge.

While no read is requested, the oscillator free-runs and follows the reference. Once the read request is seen, the block lets two full oscillator cycles finish, then halts the oscillator. It discards the first data pulse that follows the halt and restarts the oscillator on the second one. At the restart it switches the loop input source from the reference to the data, and it pulses a done flag that a downstream preamble detector uses to start counting.

The oscillator is modelled as a divider of the fast sampling clock. Its period is `PERIOD` sampling ticks, and its output is high for the first `PERIOD/2` ticks of each cycle. The read request and the data pulse input are both asynchronous to the sampling clock.

Top module: `zps_lock_seq`

## Requirements
- R1: After reset, seq_state is 0 (reference tracking), osc_run is 1, src_data is 0 and lock_done is 0.
- R2: While seq_state is 0, osc_clk toggles with a period of PERIOD sampling cycles. It is high for PERIOD/2 cycles of each period.
- R3: read_gate passes through a two-flop synchronizer. A rise of read_gate before a clock edge moves seq_state from 0 to 1 (counting) on the third clock edge.
- R4: In state 1, the oscillator keeps running until it completes two cycles. A completion is the oscillator's counter wrapping from its last tick to tick 0. Any wrap at the edge that enters state 1 is not counted. State 1 therefore lasts between PERIOD+1 and 2*PERIOD cycles and shows exactly one rising edge of osc_clk after its first cycle.
- R5: After the second completion, seq_state becomes 2 (halted, awaiting the first pulse). While seq_state is 2 or 3, osc_run and osc_clk are both 0.
- R6: data_in passes through a two-flop synchronizer, and a pulse is recognised on its rising transition. The first pulse recognised in state 2 moves the block to state 3 and does not restart the oscillator. Pulses that arrive during state 1 are ignored.
- R7: A pulse recognised in state 3 moves the block to state 4 (locked) on the third clock edge after data_in rises. In that same cycle osc_clk is 1, with its phase counter restarted at tick 0. It then stays high PERIOD/2 cycles and rises again PERIOD cycles later.
- R8: src_data is 1 exactly while seq_state is 4. It is 0 in all other states.
- R9: lock_done is 1 for exactly one cycle, the first cycle of state 4.
- R10: A fall of read_gate in any state returns seq_state to 0 on the third clock edge, with the oscillator running.
- R11: A data_in level held high counts as a single pulse, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_gate | input | 1 | Asynchronous read request |
| data_in | input | 1 | Asynchronous encoded data pulse input |
| osc_run | output | 1 | Oscillator run enable |
| osc_clk | output | 1 | Modelled oscillator output |
| src_data | output | 1 | Loop source select: 0 reference, 1 data |
| lock_done | output | 1 | One-cycle flag at restart |
| seq_state | output | 3 | Sequence state (0 ref, 1 count, 2 halt wait first, 3 halt wait second, 4 locked) |

## Verification
The checker verifies every cycle that the oscillator is silent while halted. It also checks that the done flag lasts one cycle and coincides with the first locked cycle, that the locked state is entered only from the second halt state, that the source select never points at data while the oscillator is stopped, that the counting phase never outlasts two oscillator periods, and that three cycles of low read request always leave the block in reference tracking.

The bench scenarios show the behaviours that depend on stimulus history. These are the exact synchronizer latency for both inputs, the count of oscillator edges before the halt, the discarding of the first pulse and of pulses seen while counting, a long pulse counting only once, the restarted oscillator's phase relative to the capturing edge, and aborts from the counting, halted and locked states.

// File: rtl/zps_lock_seq.sv
module zps_lock_seq #(
  parameter int PERIOD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       read_gate,
  input  logic       data_in,
  output logic       osc_run,
  output logic       osc_clk,
  output logic       src_data,
  output logic       lock_done,
  output logic [2:0] seq_state
);
  localparam int PW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int HALF = PERIOD / 2;

  typedef enum logic [2:0] {
    ST_REF    = 3'd0,
    ST_COUNT  = 3'd1,
    ST_HALT_A = 3'd2,
    ST_HALT_B = 3'd3,
    ST_LOCK   = 3'd4
  } st_t;

  st_t           state;
  logic [PW-1:0] phase;
  logic          cyc_seen;
  logic [1:0]    rg_q;
  logic [2:0]    d_q;

  wire rg_s   = rg_q[1];
  wire d_edge = d_q[1] & ~d_q[2];
  wire wrap   = osc_run && (phase == PW'(PERIOD - 1));

  assign osc_run   = (state != ST_HALT_A) && (state != ST_HALT_B);
  assign osc_clk   = osc_run && (phase < PW'(HALF));
  assign src_data  = (state == ST_LOCK);
  assign seq_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_REF;
      phase     <= '0;
      cyc_seen  <= 1'b0;
      rg_q      <= '0;
      d_q       <= '0;
      lock_done <= 1'b0;
    end else begin
      rg_q      <= {rg_q[0], read_gate};
      d_q       <= {d_q[1:0], data_in};
      lock_done <= 1'b0;
      if (osc_run) phase <= wrap ? '0 : phase + 1'b1;
      if (!rg_s) begin
        state <= ST_REF;
      end else begin
        case (state)
          ST_REF: begin
            state    <= ST_COUNT;
            cyc_seen <= 1'b0;
          end
          ST_COUNT: if (wrap) begin
            if (cyc_seen) state <= ST_HALT_A;
            cyc_seen <= 1'b1;
          end
          ST_HALT_A: if (d_edge) state <= ST_HALT_B;
          ST_HALT_B: if (d_edge) begin
            state     <= ST_LOCK;
            phase     <= '0;
            lock_done <= 1'b1;
          end
          ST_LOCK: ;
          default: state <= ST_REF;
        endcase
      end
    end
  end
endmodule

// File: rtl/zps_lock_seq_chk.sv
module zps_lock_seq_chk #(
  parameter int PERIOD = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       read_gate,
  input logic       data_in,
  input logic       osc_run,
  input logic       osc_clk,
  input logic       src_data,
  input logic       lock_done,
  input logic [2:0] seq_state
);
  localparam int CW = $clog2(2 * PERIOD + 2) + 1;
  logic [CW-1:0] count_len;

  always_ff @(posedge clk) begin
    if (!rst_n) count_len <= '0;
    else if (seq_state == 3'd1) count_len <= count_len + 1'b1;
    else count_len <= '0;
  end

  wire halted = (seq_state == 3'd2) || (seq_state == 3'd3);

  assert_halt_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!osc_run && !osc_clk));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |=> !lock_done);

  assert_done_at_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_done |-> (seq_state == 3'd4 && osc_clk && src_data));

  assert_lock_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4 && $past(seq_state) != 3'd4) |-> ($past(seq_state) == 3'd3));

  assert_src_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_data |-> osc_run);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_len <= CW'(2 * PERIOD));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(read_gate, 1) && !$past(read_gate, 2) && !$past(read_gate, 3)) |->
      (seq_state == 3'd0 && osc_run));
endmodule

bind zps_lock_seq zps_lock_seq_chk #(.PERIOD(PERIOD)) chk_i (
  .clk(clk), .rst_n(rst_n), .read_gate(read_gate), .data_in(data_in),
  .osc_run(osc_run), .osc_clk(osc_clk), .src_data(src_data),
  .lock_done(lock_done), .seq_state(seq_state)
);

// File: tb/zps_lock_seq_tb.sv
module zps_lock_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 8;
  localparam int HALF       = PERIOD / 2;

  logic clk = 0, rst_n = 0, read_gate = 0, data_in = 0;
  logic osc_run, osc_clk, src_data, lock_done;
  logic [2:0] seq_state;
  int n_checks = 0, n_fail = 0;
  bit done_all = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zps_lock_seq #(.PERIOD(PERIOD)) dut_i (
    .clk(clk), .rst_n(rst_n), .read_gate(read_gate), .data_in(data_in),
    .osc_run(osc_run), .osc_clk(osc_clk), .src_data(src_data),
    .lock_done(lock_done), .seq_state(seq_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_gap();
    read_gate = 0; data_in = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input int len);
    data_in = 1;
    repeat (len) @(negedge clk);
    data_in = 0;
  endtask

  task automatic go_to_halt();
    read_gate = 1;
    for (int i = 0; i < 4 * PERIOD && seq_state != 3'd2; i++) @(negedge clk);
    chk(seq_state == 3'd2, "R5 reach halt", seq_state, 2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(seq_state == 0 && osc_run && !src_data && !lock_done, "R1 reset state",
        {seq_state, osc_run, src_data, lock_done}, 4);
  endtask

  task automatic t_idle_period();
    int t_last = -1, t = 0, gap = 0, hi = 0;
    logic prev = osc_clk;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk); t++;
      if (osc_clk && !prev) begin
        if (t_last >= 0) gap = t - t_last;
        t_last = t;
      end
      if (osc_clk) hi++;
      prev = osc_clk;
    end
    chk(gap == PERIOD, "R2 idle period", gap, PERIOD);
    chk(hi == 4 * HALF, "R2 idle duty", hi, 4 * HALF);
  endtask

  task automatic t_full_lock();
    int n = 0, rises = 0;
    logic prev;
    read_gate = 1;
    @(negedge clk); chk(seq_state == 0, "R3 sync cycle 1", seq_state, 0);
    @(negedge clk); chk(seq_state == 0, "R3 sync cycle 2", seq_state, 0);
    @(negedge clk); chk(seq_state == 1, "R3 count entry", seq_state, 1);
    prev = osc_clk; n = 1;
    while (seq_state == 1 && n < 4 * PERIOD) begin
      @(negedge clk);
      if (seq_state == 1) begin
        n++;
        if (osc_clk && !prev) rises++;
      end
      prev = osc_clk;
    end
    chk(n >= PERIOD + 1 && n <= 2 * PERIOD, "R4 count length", n, 2 * PERIOD);
    chk(rises == 1, "R4 edges while counting", rises, 1);
    chk(seq_state == 2 && !osc_run && !osc_clk, "R5 halted", {seq_state, osc_run, osc_clk}, 8);
    repeat (4) @(negedge clk);
    chk(seq_state == 2 && !osc_clk, "R5 stays halted", seq_state, 2);
    pulse(2);
    @(negedge clk);
    chk(seq_state == 3 && !osc_run && !src_data, "R6 first pulse ignored", seq_state, 3);
    repeat (3) @(negedge clk);
    data_in = 1;
    @(negedge clk); chk(seq_state == 3, "R7 sync 1", seq_state, 3);
    @(negedge clk); chk(seq_state == 3, "R7 sync 2", seq_state, 3);
    data_in = 0;
    @(negedge clk);
    chk(seq_state == 4 && osc_clk && osc_run, "R7 restart edge", {seq_state, osc_clk}, 9);
    chk(src_data == 1, "R8 source is data", src_data, 1);
    chk(lock_done == 1, "R9 done pulse", lock_done, 1);
    @(negedge clk);
    chk(lock_done == 0, "R9 done one cycle", lock_done, 0);
    repeat (HALF - 2) @(negedge clk);
    chk(osc_clk == 1, "R7 high half", osc_clk, 1);
    @(negedge clk);
    chk(osc_clk == 0, "R7 low after half", osc_clk, 0);
    repeat (PERIOD - HALF) @(negedge clk);
    chk(osc_clk == 1, "R7 next rise at period", osc_clk, 1);
    chk(src_data == 1 && seq_state == 4, "R8 stays locked", seq_state, 4);
    read_gate = 0;
    @(negedge clk); @(negedge clk);
    chk(seq_state == 4, "R10 abort latency", seq_state, 4);
    @(negedge clk);
    chk(seq_state == 0 && osc_run && !src_data, "R10 abort from lock", seq_state, 0);
    chk(src_data == 0, "R8 source back to ref", src_data, 1'b0);
    idle_gap();
  endtask

  task automatic t_abort_count();
    read_gate = 1;
    repeat (4) @(negedge clk);
    chk(seq_state == 1, "R3 counting", seq_state, 1);
    read_gate = 0;
    repeat (3) @(negedge clk);
    chk(seq_state == 0 && osc_run, "R10 abort from count", seq_state, 0);
    idle_gap();
  endtask

  task automatic t_abort_halt();
    int rises = 0;
    logic prev;
    go_to_halt();
    read_gate = 0;
    repeat (3) @(negedge clk);
    chk(seq_state == 0 && osc_run, "R10 abort from halt", seq_state, 0);
    prev = osc_clk;
    for (int i = 0; i < PERIOD + 1; i++) begin
      @(negedge clk);
      if (osc_clk && !prev) rises++;
      prev = osc_clk;
    end
    chk(rises >= 1, "R10 oscillator resumes", rises, 1);
    idle_gap();
  endtask

  task automatic t_pulse_rules();
    read_gate = 1;
    repeat (3) @(negedge clk);
    pulse(2);
    go_to_halt();
    chk(seq_state == 2, "R6 pulse while counting ignored", seq_state, 2);
    data_in = 1;
    repeat (20) @(negedge clk);
    chk(seq_state == 3 && !osc_run, "R11 long pulse counts once", seq_state, 3);
    data_in = 0;
    repeat (3) @(negedge clk);
    pulse(1);
    repeat (2) @(negedge clk);
    chk(seq_state == 4 && osc_run, "R11 next pulse locks", seq_state, 4);
    idle_gap();
  endtask

  initial begin
    t_reset();
    t_idle_period();
    t_full_lock();
    t_abort_count();
    t_abort_halt();
    t_pulse_rules();
    done_all = 1;
  end

  initial begin
    fork
      wait (done_all);
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule